// File: doc/BRIEF.md
# Security-Banked Interrupt Priority File

This block holds one 8-bit priority value for each of `NUM_IRQ` shared interrupts. Software reaches it through a single register port. A request names a byte offset, which is also the interrupt number, and carries a secure attribute. A request is either a byte access, which touches one interrupt, or a word access, which touches four consecutive interrupts. The whole priority array is driven out flat so that arbitration logic elsewhere can use it.

Each interrupt's group bit and a global security-disable bit are inputs to the block. When security is enabled, a non-secure request sees a halved priority range. Reads return the stored value shifted up by one bit. Writes store the value shifted down by one bit with the top bit forced on. A stored non-secure priority therefore always ranks below every secure one. A non-secure request cannot see or change interrupts whose group bit is 0. Interrupt numbers below 32 and numbers at or above `NUM_IRQ` are not backed by storage: they read as zero and ignore writes.

Top module: `prio_bank_regs`

## Requirements
- R1: While `rst` is high, every priority byte is cleared to zero and `rd_valid` is low.
- R2: A secure request, or any request while `sec_disable` is high, reads and writes the addressed byte unchanged.
- R3: With `sec_disable` low, a non-secure request to an interrupt whose group bit is 0 reads as zero and leaves the stored byte unchanged.
- R4: With `sec_disable` low, a non-secure read of a group-1 interrupt returns the stored byte shifted left by one, keeping the low 8 bits.
- R5: With `sec_disable` low, a non-secure write to a group-1 interrupt stores 0x80 OR (written byte shifted right by one).
- R6: A word access at offset A covers interrupts A, A+1, A+2 and A+3. Interrupt A sits in bits [7:0] and A+3 in bits [31:24]. A need not be a multiple of four.
- R7: A word write changes nothing if A is below 32 or if A+3 is at or above `NUM_IRQ`.
- R8: A byte access to an interrupt below 32, or at or above `NUM_IRQ`, reads as zero and does not change the priority array.
- R9: Within an accepted word write, each byte applies the R3 and R5 rules using its own interrupt's group bit.
- R10: Read data and `rd_valid` appear on the clock edge after the read request. A write shows on `prio_flat` after the edge that accepts it.
- R11: In a word read, any byte whose interrupt is below 32 or at or above `NUM_IRQ` reads as zero, while the other bytes return their own values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Request strobe, one request per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | 1 = word access (four interrupts), 0 = byte access |
| acc_secure | input | 1 | Secure attribute of the request |
| acc_addr | input | ADDR_W | Byte offset, equal to the first interrupt number |
| acc_wdata | input | 32 | Write data; byte accesses use bits [7:0] |
| grp_bits | input | NUM_IRQ | Group bit per interrupt (0 = hidden from non-secure requests) |
| sec_disable | input | 1 | 1 = single security state; all requests behave as secure |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data; byte reads return the value in bits [7:0] |
| prio_flat | output | NUM_IRQ*8 | Stored priorities, interrupt i in bits [8i+7:8i] |

## Verification
The priority array is driven to the ports in full. A wrongly updated byte, or a byte written when it should have been masked, therefore shows on `prio_flat` one edge after the write that caused it. A fault in the view logic, such as a missing shift, the top bit not forced, or a hidden lane returning real data, changes only read results. Such a fault appears on `rd_data` on the edge after the read, so the stimulus reads each affected byte back under both secure and non-secure attributes. Lane-order faults and range-boundary faults are caught by word accesses that straddle interrupt 32 and the top of the implemented range.

// File: rtl/prio_bank_pkg.sv
package prio_bank_pkg;

    localparam int SHARED_FIRST = 32;
    localparam int WORD_LANES   = 4;

    typedef logic [7:0] prio_t;

    typedef struct packed {
        logic  we;
        prio_t wbyte;
        prio_t rbyte;
    } lane_res_t;

    function automatic prio_t ns_read_view(input prio_t stored);
        return {stored[6:0], 1'b0};
    endfunction

    function automatic prio_t ns_write_view(input prio_t written);
        return {1'b1, written[7:1]};
    endfunction

endpackage

// File: rtl/prio_store.sv
module prio_store
    import prio_bank_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int LANES   = 4,
    parameter int IDX_W   = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] we,
    input  logic [IDX_W-1:0] widx  [LANES],
    input  prio_t            wbyte [LANES],
    output prio_t            q     [NUM_IRQ]
);

    for (genvar e = 0; e < NUM_IRQ; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                q[e] <= '0;
            end else begin
                for (int k = 0; k < LANES; k++) begin
                    if (we[k] && (widx[k] == IDX_W'(e))) begin
                        q[e] <= wbyte[k];
                    end
                end
            end
        end

        // R1: entry is clear on the first edge after reset releases
        a_r1_entry_cleared: assert property (@(posedge clk) disable iff (rst)
            $fell(rst) |-> (q[e] == 8'h00));
    end

endmodule

// File: rtl/prio_lane.sv
module prio_lane
    import prio_bank_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int ADDR_W  = 10
) (
    input  logic [ADDR_W:0] irq,
    input  logic            used,
    input  logic            wr_gate,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic            secure,
    input  logic            sec_disable,
    input  logic            grp_bit,
    input  prio_t           cur,
    input  prio_t           wbyte_in,
    output lane_res_t       res
);

    localparam logic [ADDR_W:0] FIRST_X = (ADDR_W+1)'(SHARED_FIRST);
    localparam logic [ADDR_W:0] LIM_X   = (ADDR_W+1)'(NUM_IRQ);

    logic in_range;
    logic ns_view;
    logic hidden;

    always_comb begin
        in_range  = (irq >= FIRST_X) && (irq < LIM_X);
        ns_view   = !secure && !sec_disable;
        hidden    = ns_view && !grp_bit;
        res.we    = req_valid && req_write && used && wr_gate && in_range && !hidden;
        res.wbyte = ns_view ? ns_write_view(wbyte_in) : wbyte_in;
        if (used && in_range && !hidden) begin
            res.rbyte = ns_view ? ns_read_view(cur) : cur;
        end else begin
            res.rbyte = '0;
        end
    end

endmodule

// File: rtl/prio_bank_regs.sv
module prio_bank_regs
    import prio_bank_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int ADDR_W  = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic                 acc_wide,
    input  logic                 acc_secure,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic [31:0]          acc_wdata,
    input  logic [NUM_IRQ-1:0]   grp_bits,
    input  logic                 sec_disable,
    output logic                 rd_valid,
    output logic [31:0]          rd_data,
    output logic [NUM_IRQ*8-1:0] prio_flat
);

    localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
    localparam logic [ADDR_W:0] FIRST_X = (ADDR_W+1)'(SHARED_FIRST);
    localparam logic [ADDR_W:0] LIM_X   = (ADDR_W+1)'(NUM_IRQ);
    localparam logic [ADDR_W:0] SPAN_X  = (ADDR_W+1)'(WORD_LANES - 1);

    logic [ADDR_W:0]      base_x;
    logic                 wide_ok;
    logic                 wr_gate;
    logic [ADDR_W:0]      lane_irq  [WORD_LANES];
    logic                 lane_in   [WORD_LANES];
    logic [IDX_W-1:0]     lane_idx  [WORD_LANES];
    logic                 lane_grp  [WORD_LANES];
    prio_t                lane_cur  [WORD_LANES];
    lane_res_t            lane_res  [WORD_LANES];
    logic [WORD_LANES-1:0] st_we;
    prio_t                st_wbyte  [WORD_LANES];
    prio_t                prio_q    [NUM_IRQ];

    assign base_x  = {1'b0, acc_addr};
    assign wide_ok = (base_x >= FIRST_X) && ((base_x + SPAN_X) < LIM_X);
    assign wr_gate = acc_wide ? wide_ok : 1'b1;

    for (genvar k = 0; k < WORD_LANES; k++) begin : g_lane
        assign lane_irq[k] = base_x + (ADDR_W+1)'(k);
        assign lane_in[k]  = lane_irq[k] < LIM_X;
        assign lane_idx[k] = lane_irq[k][IDX_W-1:0];
        assign lane_grp[k] = lane_in[k] ? grp_bits[lane_idx[k]] : 1'b0;
        assign lane_cur[k] = lane_in[k] ? prio_q[lane_idx[k]] : 8'h00;

        prio_lane #(
            .NUM_IRQ (NUM_IRQ),
            .ADDR_W  (ADDR_W)
        ) u_lane (
            .irq         (lane_irq[k]),
            .used        (acc_wide || (k == 0)),
            .wr_gate     (wr_gate),
            .req_valid   (acc_valid),
            .req_write   (acc_write),
            .secure      (acc_secure),
            .sec_disable (sec_disable),
            .grp_bit     (lane_grp[k]),
            .cur         (lane_cur[k]),
            .wbyte_in    (acc_wdata[8*k +: 8]),
            .res         (lane_res[k])
        );

        assign st_we[k]    = lane_res[k].we;
        assign st_wbyte[k] = lane_res[k].wbyte;
    end

    prio_store #(
        .NUM_IRQ (NUM_IRQ),
        .LANES   (WORD_LANES),
        .IDX_W   (IDX_W)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (st_we),
        .widx  (lane_idx),
        .wbyte (st_wbyte),
        .q     (prio_q)
    );

    for (genvar e = 0; e < NUM_IRQ; e++) begin : g_flat
        assign prio_flat[8*e +: 8] = prio_q[e];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= acc_valid && !acc_write;
            if (acc_valid && !acc_write) begin
                rd_data <= {lane_res[3].rbyte, lane_res[2].rbyte,
                            lane_res[1].rbyte, lane_res[0].rbyte};
            end
        end
    end

    // Shadow of the last accepted non-secure byte write, for checking R5
    logic             chk_ns_wr_q;
    logic [IDX_W-1:0] chk_idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_ns_wr_q <= 1'b0;
            chk_idx_q   <= '0;
        end else begin
            chk_ns_wr_q <= acc_valid && acc_write && !acc_wide && !acc_secure &&
                           !sec_disable && (base_x >= FIRST_X) && lane_in[0] && lane_grp[0];
            chk_idx_q   <= lane_idx[0];
        end
    end

    a_r5_ns_top_bit: assert property (@(posedge clk) disable iff (rst)
        chk_ns_wr_q |-> prio_q[chk_idx_q][7]);

    a_r3_hidden_write_blocked: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && !acc_wide && !acc_secure && !sec_disable &&
         lane_in[0] && !lane_grp[0]) |=> $stable(prio_flat));

    a_r7_word_write_dropped: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_wide &&
         ((base_x < FIRST_X) || ((base_x + SPAN_X) >= LIM_X))) |=> $stable(prio_flat));

    a_r8_byte_oor_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && !acc_wide &&
         ((base_x < FIRST_X) || !lane_in[0])) |=> (rd_data == 32'h0));

    a_r10_read_valid_follows: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write) |=> rd_valid);

    a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && !acc_write) |=> !rd_valid);

endmodule

// File: tb/prio_bank_regs_test.sv
`timescale 1ns/1ps
module prio_bank_regs_test;

    localparam int NUM_IRQ = 64;
    localparam int ADDR_W  = 10;
    localparam int NVEC    = 29;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 acc_valid, acc_write, acc_wide, acc_secure, sec_disable;
    logic [ADDR_W-1:0]    acc_addr;
    logic [31:0]          acc_wdata;
    logic [NUM_IRQ-1:0]   grp_bits;
    logic                 rd_valid;
    logic [31:0]          rd_data;
    logic [NUM_IRQ*8-1:0] prio_flat;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    prio_bank_regs #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_wide(acc_wide), .acc_secure(acc_secure), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .grp_bits(grp_bits), .sec_disable(sec_disable),
        .rd_valid(rd_valid), .rd_data(rd_data), .prio_flat(prio_flat)
    );

    // {req, write, wide, secure, sec_disable, addr, wdata, expected read}
    localparam logic [81:0] VEC [NVEC] = '{
        {4'd2,  1'b1,1'b0,1'b1,1'b0, 10'd32, 32'h0000005A, 32'h0},        // R2
        {4'd2,  1'b0,1'b0,1'b1,1'b0, 10'd32, 32'h0, 32'h0000005A},        // R2
        {4'd3,  1'b0,1'b0,1'b0,1'b0, 10'd32, 32'h0, 32'h00000000},        // R3
        {4'd3,  1'b1,1'b0,1'b0,1'b0, 10'd32, 32'h000000FF, 32'h0},        // R3
        {4'd3,  1'b0,1'b0,1'b1,1'b0, 10'd32, 32'h0, 32'h0000005A},        // R3
        {4'd5,  1'b1,1'b0,1'b0,1'b0, 10'd33, 32'h00000064, 32'h0},        // R5
        {4'd5,  1'b0,1'b0,1'b1,1'b0, 10'd33, 32'h0, 32'h000000B2},        // R5
        {4'd4,  1'b0,1'b0,1'b0,1'b0, 10'd33, 32'h0, 32'h00000064},        // R4
        {4'd2,  1'b1,1'b0,1'b0,1'b1, 10'd34, 32'h00000011, 32'h0},        // R2
        {4'd2,  1'b0,1'b0,1'b0,1'b1, 10'd34, 32'h0, 32'h00000011},        // R2
        {4'd6,  1'b1,1'b1,1'b1,1'b0, 10'd36, 32'h44332211, 32'h0},        // R6
        {4'd6,  1'b0,1'b0,1'b1,1'b0, 10'd38, 32'h0, 32'h00000033},        // R6
        {4'd6,  1'b0,1'b1,1'b1,1'b0, 10'd36, 32'h0, 32'h44332211},        // R6
        {4'd9,  1'b1,1'b1,1'b0,1'b0, 10'd40, 32'h88664422, 32'h0},        // R9
        {4'd9,  1'b0,1'b1,1'b1,1'b0, 10'd40, 32'h0, 32'hC400A200},        // R9
        {4'd4,  1'b0,1'b1,1'b0,1'b0, 10'd40, 32'h0, 32'h88004400},        // R4
        {4'd7,  1'b1,1'b1,1'b1,1'b0, 10'd30, 32'hFFFFFFFF, 32'h0},        // R7
        {4'd7,  1'b0,1'b0,1'b1,1'b0, 10'd32, 32'h0, 32'h0000005A},        // R7
        {4'd6,  1'b1,1'b1,1'b1,1'b0, 10'd60, 32'h01020304, 32'h0},        // R6
        {4'd6,  1'b0,1'b1,1'b1,1'b0, 10'd60, 32'h0, 32'h01020304},        // R6
        {4'd7,  1'b1,1'b1,1'b1,1'b0, 10'd62, 32'hAAAAAAAA, 32'h0},        // R7
        {4'd11, 1'b0,1'b1,1'b1,1'b0, 10'd62, 32'h0, 32'h00000102},        // R11
        {4'd8,  1'b1,1'b0,1'b1,1'b0, 10'd64, 32'h00000077, 32'h0},        // R8
        {4'd8,  1'b0,1'b0,1'b1,1'b0, 10'd64, 32'h0, 32'h00000000},        // R8
        {4'd8,  1'b1,1'b0,1'b1,1'b0, 10'd5,  32'h00000077, 32'h0},        // R8
        {4'd8,  1'b0,1'b0,1'b1,1'b0, 10'd5,  32'h0, 32'h00000000},        // R8
        {4'd11, 1'b0,1'b1,1'b1,1'b0, 10'd30, 32'h0, 32'hB25A0000},        // R11
        {4'd3,  1'b0,1'b1,1'b0,1'b0, 10'd32, 32'h0, 32'h00006400},        // R3
        {4'd2,  1'b0,1'b1,1'b0,1'b1, 10'd32, 32'h0, 32'h0011B25A}         // R2
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic wr, input logic wide, input logic sec,
                         input logic dis, input logic [ADDR_W-1:0] addr,
                         input logic [31:0] wdata);
        @(negedge clk);
        acc_valid   = 1'b1;
        acc_write   = wr;
        acc_wide    = wide;
        acc_secure  = sec;
        sec_disable = dis;
        acc_addr    = addr;
        acc_wdata   = wdata;
        @(negedge clk);
        acc_valid   = 1'b0;
        sec_disable = 1'b0;
    endtask

    function automatic logic [7:0] pbyte(input int i);
        return prio_flat[8*i +: 8];
    endfunction

    initial begin
        rst = 1'b1; acc_valid = 1'b0; acc_write = 1'b0; acc_wide = 1'b0;
        acc_secure = 1'b0; sec_disable = 1'b0; acc_addr = '0; acc_wdata = '0;
        grp_bits = 64'hAAAA_AAAA_0000_0000;   // odd shared interrupts are group 1
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1", {31'b0, rd_valid}, 32'h0);
        check("R1", {24'b0, pbyte(32) | pbyte(63)}, 32'h0);

        for (int v = 0; v < NVEC; v++) begin
            logic [81:0] t;
            string tag;
            t = VEC[v];
            tag = $sformatf("R%0d", t[81:78]);
            do_op(t[77], t[76], t[75], t[74], t[73:64], t[63:32]);
            if (t[77]) begin
                check("R10", {31'b0, rd_valid}, 32'h0);   // R10: no read data after a write
            end else begin
                check("R10", {31'b0, rd_valid}, 32'h1);   // R10: read data one edge later
                check(tag, rd_data, t[31:0]);
            end
        end

        // Directed: array contents seen at the output (R5, R6, R9, R8)
        check("R5", {24'b0, pbyte(33)}, 32'h000000B2);
        check("R6", {24'b0, pbyte(63)}, 32'h00000001);
        check("R6", {24'b0, pbyte(36)}, 32'h00000011);
        check("R9", {24'b0, pbyte(40)}, 32'h00000000);
        check("R9", {24'b0, pbyte(43)}, 32'h000000C4);
        check("R8", {24'b0, pbyte(5)},  32'h00000000);
        check("R7", {24'b0, pbyte(62)}, 32'h00000002);

        // R10: a write shows on prio_flat right after its accepting edge
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_wide = 1'b0; acc_secure = 1'b1;
        acc_addr = 10'd50; acc_wdata = 32'h0000003C;
        @(posedge clk);
        #1;
        acc_valid = 1'b0;
        check("R10", {24'b0, pbyte(50)}, 32'h0000003C);

        // R1: reset mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", {24'b0, pbyte(33) | pbyte(50) | pbyte(60)}, 32'h0);
        check("R1", {31'b0, rd_valid}, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule